// File: doc/BRIEF.md
# Reset Cause Register

This block keeps one 32-bit status word. The word records why the system last came out of reset, and software can also use it to ask for a new reset. The five top bits carry the cause flags: a power-on flag, two software request flags and two push-button flags. Bits 26 down to 0 always read zero. Software reaches the word through a simple select/write port. An access hits the register only at the upper 32-bit word of an 8-byte slot. The lower word reads as zero and drops writes.

When software sets one of the two soft-request bits, the block sends a one-cycle request pulse to the system reset sequencer. A two-bit cause code goes with the pulse. An internal saturating counter tracks how many system resets have happened since the counter was last zeroed. The sequencer reports each system reset on `sys_rst_i`. The counter decides whether that reset reloads the word with the plain power-on pattern or leaves it alone. Debounced button events arrive as single-cycle pulses and set their flags directly.

Top module: `rst_cause_reg`

## Requirements
- R1: A read with `reg_sel_i` high and `reg_addr_i` equal to 4 (bit 2 set, bits 1:0 clear) returns the status word on `reg_rdata_o`. Any other address, or `reg_sel_i` low, returns zero. Bits 26:0 of the status word are always zero.
- R2: A write to any address other than 4 (for example the lower word at 0, or the unaligned address 5) leaves the status word unchanged and raises no request.
- R3: A write to address 4 first masks its data with 0xF8000000. A 1 in bit 31, 28 or 27 clears that bit, and a 0 leaves it as it was.
- R4: A 1 in bit 30 or 29 of a write to address 4 sets that bit. A 0 leaves it as it was. No write can clear these bits.
- R5: A write to address 4 with bit 30 set produces `rst_req_o` high for exactly the next cycle, with `rst_cause_o` = 2'b01. The write also zeroes the reset counter.
- R6: A write to address 4 with bit 29 set and bit 30 clear produces the same one-cycle pulse with `rst_cause_o` = 2'b10, and the counter keeps its value. When both bits are set, the cause is 2'b01.
- R7: A `sys_rst_i` cycle loads the word with 0x80000000 if the counter is zero, and otherwise leaves the word unchanged. Either way the counter then increments and saturates at its maximum. A register write in the same cycle is ignored and raises no request.
- R8: `btn_pwr_i` sets bit 28 and `btn_ext_i` sets bit 27 in the following cycle. This happens even when a clearing write or a `sys_rst_i` arrives in the same cycle.
- R9: While `pwr_rst_n` is low, the status word, the counter, `rst_req_o` and `rst_cause_o` are all zero.
- R10: `rst_cause_o` is 2'b00 whenever `rst_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Asynchronous power-up reset, active low |
| sys_rst_i | input | 1 | One-cycle notice that a system reset took place |
| reg_sel_i | input | 1 | Register access select |
| reg_wr_i | input | 1 | Write strobe, valid with `reg_sel_i` |
| reg_addr_i | input | ADDR_W (3) | Byte offset inside the 8-byte slot |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational |
| btn_pwr_i | input | 1 | Debounced power button pulse |
| btn_ext_i | input | 1 | Debounced external-reset button pulse |
| rst_req_o | output | 1 | One-cycle reset request |
| rst_cause_o | output | 2 | Cause code: 01 soft power-on, 10 soft external |

## Verification
Two pairs of events can land in the same cycle. A button pulse can meet a write that clears the same flag, and a system-reset notice can meet a soft-request write. The bench drives each pair on one clock edge: a button pulse together with the matching write-1-to-clear, and a soft power-on write together with `sys_rst_i`. Its behavioural model says the set wins in the first case. In the second, the reset notice wins and the write is dropped, so no pulse follows. Each read and each request output is compared with the model on every clock.

// File: rtl/rcr_pkg.sv
`timescale 1ns/1ps
package rcr_pkg;
  localparam int REG_W = 32;

  localparam int BIT_PWR  = 31;
  localparam int BIT_SPWR = 30;
  localparam int BIT_SEXT = 29;
  localparam int BIT_BPWR = 28;
  localparam int BIT_BEXT = 27;

  localparam logic [REG_W-1:0] WR_MASK  = 32'hF800_0000;
  localparam logic [REG_W-1:0] W1C_MASK = 32'h9800_0000;
  localparam logic [REG_W-1:0] W1S_MASK = 32'h6000_0000;
  localparam logic [REG_W-1:0] POR_ONLY = 32'h8000_0000;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'b00,
    CAUSE_SOFT_PWR = 2'b01,
    CAUSE_SOFT_EXT = 2'b10
  } cause_e;

  // Keep only the implemented flag bits of the write data.
  function automatic logic [REG_W-1:0] wr_filter(input logic [REG_W-1:0] d);
    return d & WR_MASK;
  endfunction

  // Clear the W1C bits written as 1, then OR in the W1S bits written as 1.
  function automatic logic [REG_W-1:0] apply_wr(input logic [REG_W-1:0] cur,
                                                input logic [REG_W-1:0] m);
    return (cur & ~(m & W1C_MASK)) | (m & W1S_MASK);
  endfunction

  // Soft power-on takes precedence over soft external.
  function automatic cause_e cause_of(input logic [REG_W-1:0] m);
    if (m[BIT_SPWR])      return CAUSE_SOFT_PWR;
    else if (m[BIT_SEXT]) return CAUSE_SOFT_EXT;
    else                  return CAUSE_NONE;
  endfunction

  function automatic logic [REG_W-1:0] btn_bits(input logic bp, input logic bx);
    logic [REG_W-1:0] v;
    v = '0;
    v[BIT_BPWR] = bp;
    v[BIT_BEXT] = bx;
    return v;
  endfunction
endpackage

// File: rtl/rcr_decode.sv
`timescale 1ns/1ps
module rcr_decode #(
  parameter int ADDR_W = 3
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_hit_o,
  output logic              rd_hit_o
);
  localparam int HI_BIT = 2;
  logic slot_hit;

  generate
    if (ADDR_W > HI_BIT + 1) begin : g_wide
      assign slot_hit = addr_i[HI_BIT] && (addr_i[HI_BIT-1:0] == '0)
                        && (addr_i[ADDR_W-1:HI_BIT+1] == '0);
    end else begin : g_narrow
      assign slot_hit = addr_i[HI_BIT] && (addr_i[HI_BIT-1:0] == '0);
    end
  endgenerate

  assign wr_hit_o = sel_i && wr_i && slot_hit;
  assign rd_hit_o = sel_i && slot_hit;
endmodule

// File: rtl/rcr_counter.sv
`timescale 1ns/1ps
module rcr_counter #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic pwr_rst_n,
  input  logic inc_i,
  input  logic clr_i,
  output logic first_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n)            cnt_q <= '0;
    else if (inc_i) begin
      if (cnt_q != CNT_MAX)    cnt_q <= cnt_q + 1'b1;
    end
    else if (clr_i)            cnt_q <= '0;
  end

  assign first_o = (cnt_q == '0);
endmodule

// File: rtl/rcr_status.sv
`timescale 1ns/1ps
module rcr_status
  import rcr_pkg::*;
(
  input  logic             clk,
  input  logic             pwr_rst_n,
  input  logic             sys_rst_i,
  input  logic             first_i,
  input  logic             wr_hit_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             btn_pwr_i,
  input  logic             btn_ext_i,
  output logic [REG_W-1:0] stat_o,
  output logic             fire_o,
  output cause_e           cause_o
);
  logic [REG_W-1:0] stat_q, stat_d, wmask;

  always_comb begin
    wmask   = (wr_hit_i && !sys_rst_i) ? wr_filter(wdata_i) : '0;
    fire_o  = 1'b0;
    cause_o = CAUSE_NONE;
    if (sys_rst_i) begin
      stat_d = first_i ? POR_ONLY : stat_q;
    end else begin
      stat_d  = apply_wr(stat_q, wmask);
      fire_o  = |(wmask & W1S_MASK);
      cause_o = cause_of(wmask);
    end
    stat_d = stat_d | btn_bits(btn_pwr_i, btn_ext_i);
  end

  always_ff @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n) stat_q <= '0;
    else            stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/rcr_req.sv
`timescale 1ns/1ps
module rcr_req
  import rcr_pkg::*;
(
  input  logic       clk,
  input  logic       pwr_rst_n,
  input  logic       fire_i,
  input  cause_e     cause_i,
  output logic       req_o,
  output logic [1:0] cause_o
);
  always_ff @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n) begin
      req_o   <= 1'b0;
      cause_o <= CAUSE_NONE;
    end else begin
      req_o   <= fire_i;
      cause_o <= fire_i ? cause_i : CAUSE_NONE;
    end
  end
endmodule

// File: rtl/rst_cause_reg.sv
`timescale 1ns/1ps
module rst_cause_reg
  import rcr_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              pwr_rst_n,
  input  logic              sys_rst_i,
  input  logic              reg_sel_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              btn_pwr_i,
  input  logic              btn_ext_i,
  output logic              rst_req_o,
  output logic [1:0]        rst_cause_o
);
  // Named internal events, also used by the bound checker.
  logic             wr_hit, rd_hit, first_rst, req_fire, cnt_clr;
  cause_e           req_cause;
  logic [REG_W-1:0] stat;

  rcr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel_i    (reg_sel_i),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wr_hit_o (wr_hit),
    .rd_hit_o (rd_hit)
  );

  assign cnt_clr = req_fire && (req_cause == CAUSE_SOFT_PWR);

  rcr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .pwr_rst_n (pwr_rst_n),
    .inc_i     (sys_rst_i),
    .clr_i     (cnt_clr),
    .first_o   (first_rst)
  );

  rcr_status u_stat (
    .clk       (clk),
    .pwr_rst_n (pwr_rst_n),
    .sys_rst_i (sys_rst_i),
    .first_i   (first_rst),
    .wr_hit_i  (wr_hit),
    .wdata_i   (reg_wdata_i),
    .btn_pwr_i (btn_pwr_i),
    .btn_ext_i (btn_ext_i),
    .stat_o    (stat),
    .fire_o    (req_fire),
    .cause_o   (req_cause)
  );

  rcr_req u_req (
    .clk       (clk),
    .pwr_rst_n (pwr_rst_n),
    .fire_i    (req_fire),
    .cause_i   (req_cause),
    .req_o     (rst_req_o),
    .cause_o   (rst_cause_o)
  );

  assign reg_rdata_o = rd_hit ? stat : '0;
endmodule

// File: rtl/rcr_checker.sv
`timescale 1ns/1ps
module rcr_checker #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              pwr_rst_n,
  input logic              sys_rst_i,
  input logic              reg_sel_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic [31:0]       reg_rdata_o,
  input logic              btn_pwr_i,
  input logic              btn_ext_i,
  input logic              rst_req_o,
  input logic [1:0]        rst_cause_o,
  input logic              wr_hit,
  input logic              first_rst,
  input logic              req_fire,
  input logic [31:0]       stat
);
  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    stat[26:0] == 27'd0);

  p_lo_word_zero_r1: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (reg_sel_i && !reg_addr_i[2]) |-> (reg_rdata_o == 32'd0));

  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (wr_hit && reg_wdata_i[31] && !sys_rst_i) |=> !stat[31]);

  p_soft_bits_keep_r4: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (stat[30] && !sys_rst_i) |=> stat[30]);

  p_soft_pwr_pulse_r5: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (wr_hit && reg_wdata_i[30] && !sys_rst_i) |=> (rst_req_o && rst_cause_o == 2'b01));

  p_no_spurious_req_r5: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    rst_req_o |-> $past(req_fire));

  p_soft_ext_pulse_r6: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (wr_hit && !reg_wdata_i[30] && reg_wdata_i[29] && !sys_rst_i)
      |=> (rst_req_o && rst_cause_o == 2'b10));

  p_first_load_r7: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (sys_rst_i && first_rst && !btn_pwr_i && !btn_ext_i) |=> (stat == 32'h8000_0000));

  p_later_hold_r7: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (sys_rst_i && !first_rst && !btn_pwr_i && !btn_ext_i) |=> $stable(stat));

  p_btn_sets_r8: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (btn_pwr_i || btn_ext_i) |=> (stat[28] || !$past(btn_pwr_i)) && (stat[27] || !$past(btn_ext_i)));

  p_cause_idle_r10: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    !rst_req_o |-> (rst_cause_o == 2'b00));
endmodule

bind rst_cause_reg rcr_checker #(.ADDR_W(ADDR_W)) u_rcr_chk (
  .clk         (clk),
  .pwr_rst_n   (pwr_rst_n),
  .sys_rst_i   (sys_rst_i),
  .reg_sel_i   (reg_sel_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .btn_pwr_i   (btn_pwr_i),
  .btn_ext_i   (btn_ext_i),
  .rst_req_o   (rst_req_o),
  .rst_cause_o (rst_cause_o),
  .wr_hit      (wr_hit),
  .first_rst   (first_rst),
  .req_fire    (req_fire),
  .stat        (stat)
);

// File: tb/test_rst_cause_reg.sv
`timescale 1ns/1ps
module test_rst_cause_reg;
  localparam int ADDR_W = 3;
  localparam int CNT_W  = 8;
  localparam int CNT_TOP = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              pwr_rst_n = 1'b0;
  logic              sys_rst_i = 1'b0;
  logic              reg_sel_i = 1'b0;
  logic              reg_wr_i = 1'b0;
  logic [ADDR_W-1:0] reg_addr_i = '0;
  logic [31:0]       reg_wdata_i = '0;
  logic [31:0]       reg_rdata_o;
  logic              btn_pwr_i = 1'b0;
  logic              btn_ext_i = 1'b0;
  logic              rst_req_o;
  logic [1:0]        rst_cause_o;

  always #2 clk = ~clk;   // 250 MHz

  rst_cause_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_rst_cause_reg (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .sys_rst_i(sys_rst_i),
    .reg_sel_i(reg_sel_i), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .btn_pwr_i(btn_pwr_i), .btn_ext_i(btn_ext_i),
    .rst_req_o(rst_req_o), .rst_cause_o(rst_cause_o)
  );

  // Behavioural reference state
  int unsigned m_reg, m_cnt, m_req, m_cause;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic bit addr_ok(input int unsigned a);
    return a == 4;
  endfunction

  // One clock of stimulus, starting and ending at a falling edge.
  task automatic step(input bit sel, input bit wr, input int unsigned addr,
                      input int unsigned wd, input bit sr, input bit bp,
                      input bit bx, input string tag);
    int unsigned v, exp_rd;
    reg_sel_i = sel; reg_wr_i = wr; reg_addr_i = addr[ADDR_W-1:0];
    reg_wdata_i = wd; sys_rst_i = sr; btn_pwr_i = bp; btn_ext_i = bx;
    #1;
    exp_rd = (sel && addr_ok(addr)) ? m_reg : 0;
    chk({tag, " rdata (R1)"}, reg_rdata_o, exp_rd);
    @(posedge clk);
    if (sr) begin
      if (m_cnt == 0) m_reg = 32'h8000_0000;
      if (m_cnt < CNT_TOP) m_cnt++;
      m_req = 0; m_cause = 0;
    end else begin
      v = (sel && wr && addr_ok(addr)) ? (wd & 32'hF800_0000) : 0;
      m_reg = (m_reg & ~(v & 32'h9800_0000)) | (v & 32'h6000_0000);
      if (v[30])      begin m_req = 1; m_cause = 1; m_cnt = 0; end
      else if (v[29]) begin m_req = 1; m_cause = 2; end
      else            begin m_req = 0; m_cause = 0; end
    end
    if (bp) m_reg = m_reg | 32'h1000_0000;
    if (bx) m_reg = m_reg | 32'h0800_0000;
    @(negedge clk);
    chk({tag, " req (R5)"}, rst_req_o, m_req);
    chk({tag, " cause (R10)"}, rst_cause_o, m_cause);
  endtask

  task automatic idle(input string tag);
    step(1, 0, 4, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    m_reg = 0; m_cnt = 0; m_req = 0; m_cause = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset req", rst_req_o, 0);
    chk("R9 reset cause", rst_cause_o, 0);
    pwr_rst_n = 1'b1;
    idle("R9 post-reset read");

    step(1, 0, 4, 0, 1, 0, 0, "R7 first sys reset");
    idle("R7 read after first");
    step(1, 0, 4, 0, 1, 0, 0, "R7 second sys reset");
    idle("R7 unchanged");

    step(1, 1, 0, 32'hFFFF_FFFF, 0, 0, 0, "R2 lower word write");
    step(1, 0, 0, 0, 0, 0, 0, "R1 lower word read");
    step(1, 1, 5, 32'h6000_0000, 0, 0, 0, "R2 unaligned write");
    idle("R2 check");

    step(1, 1, 4, 32'h07FF_FFFF, 0, 0, 0, "R3 reserved masked");
    step(1, 1, 4, 32'h8000_0000, 0, 0, 0, "R3 w1c bit31");
    idle("R3 check");

    step(1, 0, 4, 0, 0, 1, 0, "R8 power button");
    step(1, 0, 4, 0, 0, 0, 1, "R8 ext button");
    idle("R8 check");
    step(1, 1, 4, 32'h1800_0000, 0, 0, 0, "R3 w1c buttons");
    step(1, 1, 4, 32'h1000_0000, 0, 1, 0, "R8 set beats clear");
    idle("R8 concurrency check");

    step(1, 1, 4, 32'h2000_0000, 0, 0, 0, "R6 soft ext write");
    idle("R6 pulse ends");
    step(1, 0, 4, 0, 1, 0, 0, "R6 counter kept, sys reset");
    idle("R6 check");
    step(1, 1, 4, 32'h0000_0000, 0, 0, 0, "R4 zero write");
    idle("R4 check");

    step(1, 1, 4, 32'h6000_0000, 0, 0, 0, "R6 both soft bits");
    idle("R5 pulse ends");
    step(1, 1, 4, 32'h4000_0000, 0, 0, 0, "R5 soft pwr write");
    step(1, 1, 4, 32'h4000_0000, 0, 0, 0, "R5 back to back");
    idle("R5 check");
    step(1, 0, 4, 0, 1, 0, 1, "R7 reload with button");
    idle("R7 reload check");

    step(1, 1, 4, 32'h4000_0000, 1, 0, 0, "R7 write during sys reset");
    idle("R7 write ignored");

    step(1, 1, 4, 32'h9800_0000, 0, 0, 0, "R3 clear all");
    for (int i = 0; i < CNT_TOP + 5; i++) step(0, 0, 4, 0, 1, 0, 0, "R7 saturate");
    idle("R7 no reload after saturation");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule